// File: doc/BRIEF.md
# Dual-Pipeline Structural Hazard Tracker

This block sits at the issue point of an in-order core that has two back-end pipelines. The execute pipeline has four stages: shift or multiply pass 1, ALU or multiply pass 2, saturate or multiply pass 3, and a writeback stage. The ALU and multiply-accumulate paths move through these stages in lockstep and share the writeback stage. The memory pipeline is separate and has its own four stages: address generation, cache access 1, cache access 2 and its own writeback. Each cycle the issue logic presents a 4-bit instruction class and a request strobe. The tracker decides whether the stage-reservation pattern of that class fits around the work already in flight.

When the pattern fits, the tracker books it and the instruction issues. When it does not fit, the tracker raises `stall`. The issue logic then holds the same request until the stall clears. Stages are booked in a per-stage window that looks several cycles ahead. Two 4-bit vectors report which stages are occupied in the current cycle. Operand dependencies are not tracked. The front end is not modelled either.

Top module: `dual_pipe_hazard_tracker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `execBusy`, `lsuBusy` and (with no request) `stall` are all zero. A reset given while work is in flight discards every booking.
- R2: Classes 0 (plain ALU), 1 (ALU with constant shift) and 7 (16x16 or dual multiply) are accepted on the edge where `issueValid` is sampled without stall. In the 1st, 2nd, 3rd and 4th cycles after that edge, `execBusy` is 0001, 0010, 0100 and 1000 respectively. Bit 0 is the first execute stage and bit 3 is the execute writeback.
- R3: Classes 2 (ALU shifted by register), 3 (multiply), 4 (multiply setting flags) and 9 (most-significant-word multiply) hold execute stage 1 for two cycles. They then use stages 2, 3 and writeback for one cycle each.
- R4: Classes 5 and 6 (long multiply and long multiply-accumulate) hold execute stage 1 for three cycles. They then use stages 2 and 3 for one cycle each and hold writeback for two cycles.
- R5: Class 8 (16x16 multiply with 64-bit accumulate) holds execute stage 1 for two cycles, uses stages 2 and 3 once each, and holds writeback for two cycles.
- R6: Classes 10 (load), 11 (byte load) and 12 (store) occupy memory address stage (`lsuBusy` bit 0) and execute stage 1 in the same first cycle. They then use cache stage 1, cache stage 2 and memory writeback (`lsuBusy` bits 1, 2, 3) for one cycle each.
- R7: Class 13 (load or store of 3 or 4 registers) follows R6, except that it holds cache stage 1 for two cycles.
- R8: Classes 14 (branch) and 15 (call) book no stage and never stall.
- R9: `stall` is high exactly when `issueValid` is high and the class pattern would need a stage already booked for the same future cycle. A stalled request books nothing, even if it is withdrawn.
- R10: Requests whose patterns never overlap issue on consecutive cycles without stall. Examples are back-to-back plain ALU ops and back-to-back single loads.
- R11: A held stalled request is accepted in the first cycle its whole pattern fits. A multiply followed by an ALU op stalls 1 cycle. A 64-bit-accumulate 16x16 multiply followed by an ALU op stalls 2 cycles. A long multiply followed by an ALU op stalls 3 cycles. Two 3/4-register transfers in a row stall 1 cycle.
- R12: The memory pipeline shares only execute stage 1 with the execute pipeline. A load behind a long multiply stalls 2 cycles, which is set by stage 1 alone and not by the writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all bookings |
| issueValid | input | 1 | An instruction is requesting issue this cycle |
| issueClass | input | 4 | Instruction class code of the request (0 to 15, see R2 to R8) |
| stall | output | 1 | Request cannot issue this cycle; hold it |
| execBusy | output | 4 | Execute stages occupied now: bit 0 stage 1 through bit 3 writeback |
| lsuBusy | output | 4 | Memory stages occupied now: bit 0 address through bit 3 writeback |

## Verification
A wrong booking in the look-ahead window cannot stay hidden. Within at most the window depth of cycles, it either shows up on the busy vectors, or it makes a later request stall for the wrong number of cycles. The directed scenarios therefore check each class's busy trace cycle by cycle, including the cycle after it drains. They also count the stall cycles for pairs whose overlap lies in different stages: first stage, writeback and cache stage 1. A stall that wrongly books part of its pattern shows up in the busy trace during the cycle after it is withdrawn.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // booked resources, one look-ahead window each
  localparam int NUM_RES = 8;
  localparam int RES_EX1 = 0;
  localparam int RES_EX2 = 1;
  localparam int RES_EX3 = 2;
  localparam int RES_EWB = 3;
  localparam int RES_LAG = 4;
  localparam int RES_DC1 = 5;
  localparam int RES_DC2 = 6;
  localparam int RES_LWB = 7;

  typedef enum logic [3:0] {
    CLS_ALU         = 4'd0,
    CLS_ALU_SHIMM   = 4'd1,
    CLS_ALU_SHREG   = 4'd2,
    CLS_MUL         = 4'd3,
    CLS_MUL_FLG     = 4'd4,
    CLS_MULL        = 4'd5,
    CLS_MULL_FLG    = 4'd6,
    CLS_MUL16       = 4'd7,
    CLS_MUL16_ACC64 = 4'd8,
    CLS_MUL_HI      = 4'd9,
    CLS_LOAD        = 4'd10,
    CLS_LOAD_BYTE   = 4'd11,
    CLS_STORE       = 4'd12,
    CLS_MEM_MULTI   = 4'd13,
    CLS_BRANCH      = 4'd14,
    CLS_CALL        = 4'd15
  } insnClass_e;

  // strobes from control to the reservation datapath
  typedef struct packed {
    logic reserve;
    logic stall;
  } ctrlStrobe_t;

endpackage

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int HORIZON = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             issueValid,
  input  logic [3:0]                       issueClass,
  input  logic [NUM_RES-1:0][HORIZON-1:0]  occ,
  output logic [NUM_RES-1:0][HORIZON-1:0]  pattern,
  output ctrlStrobe_t                      strobe
);

  int  lenE1;
  int  lenWb;
  int  lenDc1;
  logic isExec;
  logic isMem;
  logic collide;

  // class decode into stage lengths
  always_comb begin
    isExec = 1'b0;
    isMem  = 1'b0;
    lenE1  = 1;
    lenWb  = 1;
    lenDc1 = 1;
    case (issueClass)
      CLS_ALU, CLS_ALU_SHIMM, CLS_MUL16: isExec = 1'b1;
      CLS_ALU_SHREG, CLS_MUL, CLS_MUL_FLG, CLS_MUL_HI: begin
        isExec = 1'b1;
        lenE1  = 2;
      end
      CLS_MUL16_ACC64: begin
        isExec = 1'b1;
        lenE1  = 2;
        lenWb  = 2;
      end
      CLS_MULL, CLS_MULL_FLG: begin
        isExec = 1'b1;
        lenE1  = 3;
        lenWb  = 2;
      end
      CLS_LOAD, CLS_LOAD_BYTE, CLS_STORE: isMem = 1'b1;
      CLS_MEM_MULTI: begin
        isMem  = 1'b1;
        lenDc1 = 2;
      end
      default: begin
        isExec = 1'b0;
        isMem  = 1'b0;
      end
    endcase
  end

  // expand lengths into a per-resource reservation table
  always_comb begin
    pattern = '0;
    for (int k = 0; k < HORIZON; k++) begin
      if (isExec) begin
        pattern[RES_EX1][k] = (k < lenE1);
        pattern[RES_EX2][k] = (k == lenE1);
        pattern[RES_EX3][k] = (k == lenE1 + 1);
        pattern[RES_EWB][k] = (k >= lenE1 + 2) && (k < lenE1 + 2 + lenWb);
      end
      if (isMem) begin
        pattern[RES_LAG][k] = (k == 0);
        pattern[RES_EX1][k] = (k == 0);
        pattern[RES_DC1][k] = (k >= 1) && (k < 1 + lenDc1);
        pattern[RES_DC2][k] = (k == 1 + lenDc1);
        pattern[RES_LWB][k] = (k == 2 + lenDc1);
      end
    end
  end

  // compare against bookings as they will stand after the next shift
  always_comb begin
    collide = 1'b0;
    for (int r = 0; r < NUM_RES; r++) begin
      collide = collide | (|((occ[r] >> 1) & pattern[r]));
    end
  end

  assign strobe.stall   = issueValid & collide;
  assign strobe.reserve = issueValid & ~collide;

  a_r8_branch_no_stall: assert property (@(posedge clk) disable iff (rst)
    (issueValid && (issueClass == CLS_BRANCH || issueClass == CLS_CALL)) |-> !strobe.stall);

  a_r9_stall_needs_request: assert property (@(posedge clk) disable iff (rst)
    strobe.stall |-> issueValid);

endmodule

// File: rtl/hzd_datapath.sv
module hzd_datapath
  import hzd_pkg::*;
#(
  parameter int HORIZON = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  ctrlStrobe_t                      strobe,
  input  logic [NUM_RES-1:0][HORIZON-1:0]  pattern,
  output logic [NUM_RES-1:0][HORIZON-1:0]  occ
);

  // one shifting window per resource: bit k = booked k cycles from now
  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    always_ff @(posedge clk) begin
      if (rst) begin
        occ[r] <= '0;
      end else begin
        occ[r] <= (occ[r] >> 1) | (strobe.reserve ? pattern[r] : '0);
      end
    end

    a_r9_no_booking_on_stall: assert property (@(posedge clk) disable iff (rst)
      !strobe.reserve |=> (occ[r] == ($past(occ[r]) >> 1)));
  end

  // stage ordering inside each pipeline
  a_r2_ex2_follows_ex1: assert property (@(posedge clk) disable iff (rst)
    occ[RES_EX2][0] |-> $past(occ[RES_EX1][0]));
  a_r2_ex3_follows_ex2: assert property (@(posedge clk) disable iff (rst)
    occ[RES_EX3][0] |-> $past(occ[RES_EX2][0]));
  a_r4_ewb_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(occ[RES_EWB][0]) |-> $past(occ[RES_EX3][0]));
  a_r6_agen_with_ex1: assert property (@(posedge clk) disable iff (rst)
    occ[RES_LAG][0] |-> occ[RES_EX1][0]);
  a_r6_dc2_follows_dc1: assert property (@(posedge clk) disable iff (rst)
    occ[RES_DC2][0] |-> $past(occ[RES_DC1][0]));
  a_r6_lwb_follows_dc2: assert property (@(posedge clk) disable iff (rst)
    occ[RES_LWB][0] |-> $past(occ[RES_DC2][0]));

endmodule

// File: rtl/dual_pipe_hazard_tracker.sv
module dual_pipe_hazard_tracker
  import hzd_pkg::*;
#(
  parameter int HORIZON = 8  // must cover the longest pattern (7 cycles)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       issueValid,
  input  logic [3:0] issueClass,
  output logic       stall,
  output logic [3:0] execBusy,
  output logic [3:0] lsuBusy
);

  logic [NUM_RES-1:0][HORIZON-1:0] occ;
  logic [NUM_RES-1:0][HORIZON-1:0] pattern;
  ctrlStrobe_t                     strobe;

  hzd_ctrl #(.HORIZON(HORIZON)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .issueValid (issueValid),
    .issueClass (issueClass),
    .occ        (occ),
    .pattern    (pattern),
    .strobe     (strobe)
  );

  hzd_datapath #(.HORIZON(HORIZON)) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .pattern (pattern),
    .occ     (occ)
  );

  assign stall    = strobe.stall;
  assign execBusy = {occ[RES_EWB][0], occ[RES_EX3][0], occ[RES_EX2][0], occ[RES_EX1][0]};
  assign lsuBusy  = {occ[RES_LWB][0], occ[RES_DC2][0], occ[RES_DC1][0], occ[RES_LAG][0]};

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (execBusy == 4'b0 && lsuBusy == 4'b0));

endmodule

// File: tb/test_dual_pipe_hazard_tracker.sv
module test_dual_pipe_hazard_tracker;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issueValid = 1'b0;
  logic [3:0] issueClass = 4'd0;
  logic       stall;
  logic [3:0] execBusy;
  logic [3:0] lsuBusy;

  int nTests = 0;
  int nFail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_pipe_hazard_tracker i_dual_pipe_hazard_tracker (
    .clk        (clk),
    .rst        (rst),
    .issueValid (issueValid),
    .issueClass (issueClass),
    .stall      (stall),
    .execBusy   (execBusy),
    .lsuBusy    (lsuBusy)
  );

  task automatic chk(string req, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    issueValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "execBusy after reset", int'(execBusy), 0);
    chk("R1", "lsuBusy after reset", int'(lsuBusy), 0);
    chk("R1", "stall after reset", int'(stall), 0);
  endtask

  // one class alone; masks give bit k = busy k cycles after the accept edge
  task automatic runSingle(string req, logic [3:0] cls,
                           logic [7:0] e1, logic [7:0] e2, logic [7:0] e3, logic [7:0] ew,
                           logic [7:0] la, logic [7:0] d1, logic [7:0] d2, logic [7:0] lw);
    doReset();
    issueClass = cls;
    issueValid = 1'b1;
    #1;
    chk(req, $sformatf("stall on empty pipe cls %0d", cls), int'(stall), 0);
    @(negedge clk);
    issueValid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk(req, $sformatf("cls %0d execBusy offset %0d", cls, k), int'(execBusy),
          int'({ew[k], e3[k], e2[k], e1[k]}));
      chk(req, $sformatf("cls %0d lsuBusy offset %0d", cls, k), int'(lsuBusy),
          int'({lw[k], d2[k], d1[k], la[k]}));
      @(negedge clk);
    end
  endtask

  // first op, then second held until accepted; count stall cycles
  task automatic stallPair(string req, logic [3:0] first, logic [3:0] second, int expStalls);
    int n;
    doReset();
    issueClass = first;
    issueValid = 1'b1;
    @(negedge clk);
    issueClass = second;
    n = 0;
    for (int guard = 0; guard < 20; guard++) begin
      #1;
      if (!stall) break;
      n++;
      @(negedge clk);
    end
    @(negedge clk);
    issueValid = 1'b0;
    chk(req, $sformatf("stall cycles cls %0d after cls %0d", second, first), n, expStalls);
  endtask

  // stalled request withdrawn: only the multiply remains booked
  task automatic stallDrop();
    logic [7:0] e1 = 8'h03, e2 = 8'h04, e3 = 8'h08, ew = 8'h10;
    doReset();
    issueClass = 4'd3;
    issueValid = 1'b1;
    @(negedge clk);
    issueClass = 4'd0;
    #1;
    chk("R9", "ALU behind multiply stalls", int'(stall), 1);
    @(negedge clk);
    issueValid = 1'b0;
    for (int k = 1; k < 8; k++) begin
      chk("R9", $sformatf("withdrawn stall leaves trace offset %0d", k), int'(execBusy),
          int'({ew[k], e3[k], e2[k], e1[k]}));
      @(negedge clk);
    end
    chk("R9", "no request no stall", int'(stall), 0);
  endtask

  task automatic backToBack(string req, logic [3:0] cls);
    doReset();
    issueClass = cls;
    issueValid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(req, $sformatf("back-to-back cls %0d issue %0d", cls, k), int'(stall), 0);
      @(negedge clk);
    end
    issueValid = 1'b0;
  endtask

  task automatic resetMidFlight();
    doReset();
    issueClass = 4'd5;
    issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "execBusy during reset", int'(execBusy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "execBusy after mid-flight reset", int'(execBusy), 0);
    issueClass = 4'd0;
    issueValid = 1'b1;
    #1;
    chk("R1", "no stall after mid-flight reset", int'(stall), 0);
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    doReset();
    // single-pass execute
    runSingle("R2", 4'd0,  8'h01, 8'h02, 8'h04, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00);
    runSingle("R2", 4'd1,  8'h01, 8'h02, 8'h04, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00);
    runSingle("R2", 4'd7,  8'h01, 8'h02, 8'h04, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00);
    // two-cycle first stage
    runSingle("R3", 4'd2,  8'h03, 8'h04, 8'h08, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
    runSingle("R3", 4'd3,  8'h03, 8'h04, 8'h08, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
    runSingle("R3", 4'd4,  8'h03, 8'h04, 8'h08, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
    runSingle("R3", 4'd9,  8'h03, 8'h04, 8'h08, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
    // long multiplies
    runSingle("R4", 4'd5,  8'h07, 8'h08, 8'h10, 8'h60, 8'h00, 8'h00, 8'h00, 8'h00);
    runSingle("R4", 4'd6,  8'h07, 8'h08, 8'h10, 8'h60, 8'h00, 8'h00, 8'h00, 8'h00);
    runSingle("R5", 4'd8,  8'h03, 8'h04, 8'h08, 8'h30, 8'h00, 8'h00, 8'h00, 8'h00);
    // memory
    runSingle("R6", 4'd10, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h04, 8'h08);
    runSingle("R6", 4'd11, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h04, 8'h08);
    runSingle("R6", 4'd12, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h04, 8'h08);
    runSingle("R7", 4'd13, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h06, 8'h08, 8'h10);
    runSingle("R8", 4'd14, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    runSingle("R8", 4'd15, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    // collisions
    stallPair("R11", 4'd3,  4'd0,  1);
    stallPair("R11", 4'd8,  4'd0,  2);
    stallPair("R11", 4'd5,  4'd0,  3);
    stallPair("R11", 4'd13, 4'd13, 1);
    stallPair("R12", 4'd5,  4'd10, 2);
    stallPair("R8",  4'd5,  4'd14, 0);
    stallPair("R10", 4'd0,  4'd10, 0);
    stallDrop();
    backToBack("R10", 4'd0);
    backToBack("R10", 4'd10);
    resetMidFlight();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule